// File: doc/BRIEF.md
# Multi-Pattern Serial Test Bit Generator

This block emits a serial test stream, one bit for each clock cycle in which its advance enable is high. A configuration write captures a bank bit, a 3-bit code, an output-invert flag and the parameters of the word-based modes. From these the block picks one of several maximal-length shift register sequences, a zero-limited variant of the 2^20-1 sequence, a repeating user-defined pattern, or an alternating word pattern. Codes with no meaning put out a steady zero and raise an error flag.

Every configuration write restarts the selected generator from a fixed point. The shift register is loaded with all ones, and the word counters return to their first bit. Each new selection therefore begins a known, repeatable sequence, which a receiver can lock to. Gapped clocks are handled by holding the advance enable low. While it is low, the output and all generator state stay frozen.

Top module: `prbs_test_gen`

## Requirements
- R1: After reset, tx_bit is 0 and sel_err is 0. The active selection is bank 0, code 000, non-inverted, with a repeat length of 0, a user pattern of 0, an alternating word of 0 and a repeat count of 0.
- R2: The shift register sequences are decoded from {cfg_bank, cfg_sel}. Bank 0 gives 000 = 2^7-1 (x^7+x^6+1), 001 = 2^11-1 (x^11+x^9+1) and 010 = 2^15-1 (x^15+x^14+1). Bank 1 gives 000 = 2^9-1 (x^9+x^5+1), 001 = 2^20-1 (x^20+x^3+1) and 010 = 2^23-1 (x^23+x^18+1). For degree N and middle term T, the emitted bits obey o[n+N] = o[n] xor o[n+N-T], with o[0..N-1] all 1, and the register never reaches all zeros.
- R3: Bank 0 code 011 emits the x^20+x^3+1 sequence with one change: a bit is forced to 1 whenever the following 14 raw sequence bits are all 0. No run of more than 14 zeros ever appears.
- R4: A cycle with cfg_wr high captures the configuration, restarts every generator and clears tx_bit to 0. It wins over bit_en in the same cycle, so no bit is emitted in that cycle.
- R5: Bank 0 code 100 repeats bits 0..cfg_rep_len of cfg_user_pat, starting with bit 0, with a period of cfg_rep_len+1.
- R6: Bank 0 code 101 sends the 16-bit cfg_alt_word, LSB first, cfg_alt_reps+1 times. It then sends the complement of the word the same number of times, and the cycle repeats.
- R7: Bank 0 codes 110 and 111 and bank 1 codes 011 and 1XX are illegal. While one of them is selected, sel_err is 1 and tx_bit stays 0 whatever the invert flag is. For all legal codes, sel_err is 0.
- R8: With the captured invert flag at 1, every emitted bit of a legal selection is complemented.
- R9: In a cycle with bit_en low and cfg_wr low, tx_bit keeps its value and the generator position does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe; restarts generators |
| cfg_bank | input | 1 | Bank select captured on write |
| cfg_sel | input | 3 | Pattern code captured on write |
| cfg_inv | input | 1 | Output invert flag captured on write |
| cfg_rep_len | input | 4 | Repeating pattern length minus one |
| cfg_user_pat | input | 32 | Repeating pattern bits, LSB sent first |
| cfg_alt_word | input | 16 | Word used by the alternating mode |
| cfg_alt_reps | input | 4 | Repeats of each word phase minus one |
| bit_en | input | 1 | Advance enable; one bit per enabled cycle |
| tx_bit | output | 1 | Registered serial test bit |
| sel_err | output | 1 | High while the captured selection is illegal |

## Verification
A configuration write and a bit advance can land in the same cycle. The write must win: tx_bit clears, and the next enabled cycle must emit the first bit of the new sequence rather than a bit of the old one. The bench drives bit_en high during many of its writes, both in directed cases and in random configurations with gapped enables. It judges the outcome by comparing every later bit against a bench model that restarts only on the write.

// File: rtl/prbs_gen_pkg.sv
package prbs_gen_pkg;

  localparam int LFSR_MAX = 23;
  localparam int QRSS_DEG = 20;
  localparam int QRSS_RUN = 14;

  typedef enum logic [3:0] {
    MD_P7, MD_P9, MD_P11, MD_P15, MD_P20, MD_P23,
    MD_QRSS, MD_REP, MD_ALT, MD_BAD
  } gen_mode_t;

  function automatic gen_mode_t decode_mode(input logic bank, input logic [2:0] code);
    gen_mode_t m;
    m = MD_BAD;
    if (!bank) begin
      case (code)
        3'd0: m = MD_P7;
        3'd1: m = MD_P11;
        3'd2: m = MD_P15;
        3'd3: m = MD_QRSS;
        3'd4: m = MD_REP;
        3'd5: m = MD_ALT;
        default: m = MD_BAD;
      endcase
    end else begin
      case (code)
        3'd0: m = MD_P9;
        3'd1: m = MD_P20;
        3'd2: m = MD_P23;
        default: m = MD_BAD;
      endcase
    end
    return m;
  endfunction

  function automatic int poly_degree(input gen_mode_t m);
    case (m)
      MD_P9:           return 9;
      MD_P11:          return 11;
      MD_P15:          return 15;
      MD_P20, MD_QRSS: return QRSS_DEG;
      MD_P23:          return 23;
      default:         return 7;
    endcase
  endfunction

  function automatic int poly_mid(input gen_mode_t m);
    case (m)
      MD_P9:           return 5;
      MD_P11:          return 9;
      MD_P15:          return 14;
      MD_P20, MD_QRSS: return 3;
      MD_P23:          return 18;
      default:         return 6;
    endcase
  endfunction

  function automatic logic pick_bit(input logic [LFSR_MAX-1:0] s, input int idx);
    logic b;
    b = 1'b0;
    for (int i = 0; i < LFSR_MAX; i++)
      if (i == idx) b = s[i];
    return b;
  endfunction

  function automatic logic [LFSR_MAX-1:0] degree_mask(input int deg);
    logic [LFSR_MAX-1:0] msk;
    for (int i = 0; i < LFSR_MAX; i++)
      msk[i] = (i < deg);
    return msk;
  endfunction

  function automatic logic [LFSR_MAX-1:0] lfsr_advance(input logic [LFSR_MAX-1:0] s,
                                                       input int deg, input int mid);
    logic fb;
    fb = pick_bit(s, deg - 1) ^ pick_bit(s, mid - 1);
    return {s[LFSR_MAX-2:0], fb};
  endfunction

  function automatic logic qrss_fill(input logic [LFSR_MAX-1:0] s);
    return ~|s[QRSS_DEG-2 -: QRSS_RUN];
  endfunction

endpackage

// File: rtl/prbs_lfsr_core.sv
module prbs_lfsr_core
  import prbs_gen_pkg::*;
#(
  parameter int RUN_W = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      reseed,
  input  logic      step,
  input  gen_mode_t mode,
  output logic      gen_bit
);

  logic [LFSR_MAX-1:0] state_q;
  logic [RUN_W-1:0]    zrun_q;
  int                  deg;
  int                  mid;
  logic                raw_bit;
  logic                fill_one;

  always_comb begin
    deg      = poly_degree(mode);
    mid      = poly_mid(mode);
    raw_bit  = pick_bit(state_q, deg - 1);
    fill_one = (mode == MD_QRSS) && qrss_fill(state_q);
    gen_bit  = raw_bit | fill_one;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || reseed) begin
      state_q <= '1;
    end else if (step) begin
      state_q <= lfsr_advance(state_q, deg, mid);
    end
  end

  // zero-run observer for the QRSS limit
  always_ff @(posedge clk) begin
    if (!rst_n || reseed) begin
      zrun_q <= '0;
    end else if (step) begin
      if (gen_bit) zrun_q <= '0;
      else if (zrun_q != '1) zrun_q <= zrun_q + 1'b1;
    end
  end

  assert_no_lockup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q & degree_mask(deg)) != '0);

  assert_qrss_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_QRSS) |-> (int'(zrun_q) <= QRSS_RUN));

endmodule

// File: rtl/prbs_word_src.sv
module prbs_word_src #(
  parameter int USER_W = 32,
  parameter int ALT_W  = 16,
  parameter int LEN_W  = 4,
  parameter int REPS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reseed,
  input  logic              step,
  input  logic [LEN_W-1:0]  rep_len,
  input  logic [USER_W-1:0] user_pat,
  input  logic [ALT_W-1:0]  alt_word,
  input  logic [REPS_W-1:0] alt_reps,
  output logic              rep_bit,
  output logic              alt_bit
);

  localparam int AIDX_W = $clog2(ALT_W);
  localparam logic [AIDX_W-1:0] ALT_LAST = AIDX_W'(ALT_W - 1);

  logic [LEN_W-1:0]  rep_idx_q;
  logic [AIDX_W-1:0] bit_idx_q;
  logic [REPS_W-1:0] word_cnt_q;
  logic              phase_q;
  logic              word_end;
  logic              phase_end;

  assign word_end  = (bit_idx_q == ALT_LAST);
  assign phase_end = word_end && (word_cnt_q == alt_reps);
  assign rep_bit   = user_pat[rep_idx_q];
  assign alt_bit   = alt_word[bit_idx_q] ^ phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n || reseed) begin
      rep_idx_q <= '0;
    end else if (step) begin
      rep_idx_q <= (rep_idx_q == rep_len) ? '0 : rep_idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || reseed) begin
      bit_idx_q  <= '0;
      word_cnt_q <= '0;
      phase_q    <= 1'b0;
    end else if (step) begin
      bit_idx_q <= word_end ? '0 : bit_idx_q + 1'b1;
      if (word_end) begin
        word_cnt_q <= phase_end ? '0 : word_cnt_q + 1'b1;
        if (phase_end) phase_q <= ~phase_q;
      end
    end
  end

  assert_rep_span_R5: assert property (@(posedge clk) disable iff (!rst_n || reseed)
    rep_idx_q <= rep_len);

  assert_phase_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !reseed && !word_end) |=> $stable(phase_q));

endmodule

// File: rtl/prbs_test_gen.sv
module prbs_test_gen
  import prbs_gen_pkg::*;
#(
  parameter int USER_W = 32,
  parameter int ALT_W  = 16,
  parameter int LEN_W  = 4,
  parameter int REPS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_bank,
  input  logic [2:0]        cfg_sel,
  input  logic              cfg_inv,
  input  logic [LEN_W-1:0]  cfg_rep_len,
  input  logic [USER_W-1:0] cfg_user_pat,
  input  logic [ALT_W-1:0]  cfg_alt_word,
  input  logic [REPS_W-1:0] cfg_alt_reps,
  input  logic              bit_en,
  output logic              tx_bit,
  output logic              sel_err
);

  logic              bank_q;
  logic [2:0]        sel_q;
  logic              inv_q;
  logic [LEN_W-1:0]  rep_len_q;
  logic [USER_W-1:0] user_pat_q;
  logic [ALT_W-1:0]  alt_word_q;
  logic [REPS_W-1:0] alt_reps_q;

  gen_mode_t mode;
  logic      step;
  logic      illegal;
  logic      lfsr_bit;
  logic      rep_bit;
  logic      alt_bit;
  logic      src_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q     <= 1'b0;
      sel_q      <= '0;
      inv_q      <= 1'b0;
      rep_len_q  <= '0;
      user_pat_q <= '0;
      alt_word_q <= '0;
      alt_reps_q <= '0;
    end else if (cfg_wr) begin
      bank_q     <= cfg_bank;
      sel_q      <= cfg_sel;
      inv_q      <= cfg_inv;
      rep_len_q  <= cfg_rep_len;
      user_pat_q <= cfg_user_pat;
      alt_word_q <= cfg_alt_word;
      alt_reps_q <= cfg_alt_reps;
    end
  end

  assign mode    = decode_mode(bank_q, sel_q);
  assign illegal = (mode == MD_BAD);
  assign step    = bit_en && !cfg_wr;
  assign sel_err = illegal;

  prbs_lfsr_core u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .reseed  (cfg_wr),
    .step    (step),
    .mode    (mode),
    .gen_bit (lfsr_bit)
  );

  prbs_word_src #(
    .USER_W (USER_W),
    .ALT_W  (ALT_W),
    .LEN_W  (LEN_W),
    .REPS_W (REPS_W)
  ) u_words (
    .clk      (clk),
    .rst_n    (rst_n),
    .reseed   (cfg_wr),
    .step     (step),
    .rep_len  (rep_len_q),
    .user_pat (user_pat_q),
    .alt_word (alt_word_q),
    .alt_reps (alt_reps_q),
    .rep_bit  (rep_bit),
    .alt_bit  (alt_bit)
  );

  always_comb begin
    case (mode)
      MD_REP:  src_bit = rep_bit;
      MD_ALT:  src_bit = alt_bit;
      default: src_bit = lfsr_bit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_wr) begin
      tx_bit <= 1'b0;
    end else if (step) begin
      tx_bit <= illegal ? 1'b0 : (src_bit ^ inv_q);
    end
  end

  assert_write_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !tx_bit);

  assert_bad_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |-> !tx_bit);

  assert_gap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !cfg_wr) |=> $stable(tx_bit));

endmodule

// File: tb/prbs_test_gen_bench.sv
`timescale 1ns/1ps
module prbs_test_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr, cfg_bank, cfg_inv, bit_en;
  logic [2:0]  cfg_sel;
  logic [3:0]  cfg_rep_len, cfg_alt_reps;
  logic [31:0] cfg_user_pat;
  logic [15:0] cfg_alt_word;
  logic        tx_bit, sel_err;

  always #2.5 clk = ~clk;

  prbs_test_gen u_prbs_test_gen (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_bank(cfg_bank),
    .cfg_sel(cfg_sel), .cfg_inv(cfg_inv), .cfg_rep_len(cfg_rep_len),
    .cfg_user_pat(cfg_user_pat), .cfg_alt_word(cfg_alt_word),
    .cfg_alt_reps(cfg_alt_reps), .bit_en(bit_en), .tx_bit(tx_bit),
    .sel_err(sel_err)
  );

  int errs = 0;
  int checks = 0;
  bit done = 0;

  // bench model: window w[i] holds the bit due i steps from now
  logic [22:0] mw;
  int          mkind, mn, mt, mri, mbi, mwc;
  logic        mph, minv, last_tx;
  logic [31:0] mpat;
  logic [3:0]  mlen, mreps;
  logic [15:0] mword;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_load(input logic b, input logic [2:0] s, input logic inv,
                            input logic [3:0] len, input logic [31:0] pat,
                            input logic [15:0] word, input logic [3:0] reps);
    mkind = 0; mn = 7; mt = 6;
    case ({b, s})
      4'b0000: begin mkind = 0; mn = 7;  mt = 6;  end
      4'b0001: begin mkind = 0; mn = 11; mt = 9;  end
      4'b0010: begin mkind = 0; mn = 15; mt = 14; end
      4'b0011: begin mkind = 1; mn = 20; mt = 3;  end
      4'b0100: mkind = 2;
      4'b0101: mkind = 3;
      4'b1000: begin mkind = 0; mn = 9;  mt = 5;  end
      4'b1001: begin mkind = 0; mn = 20; mt = 3;  end
      4'b1010: begin mkind = 0; mn = 23; mt = 18; end
      default: mkind = 4;
    endcase
    mw = '1; mri = 0; mbi = 0; mwc = 0; mph = 1'b0;
    minv = inv; mlen = len; mpat = pat; mword = word; mreps = reps;
  endtask

  task automatic model_next(output logic e);
    logic o, nb;
    case (mkind)
      0: o = mw[0];
      1: o = mw[0] | (mw[14:1] == 14'd0);
      2: o = mpat[mri];
      3: o = mword[mbi] ^ mph;
      default: o = 1'b0;
    endcase
    if (mkind < 2) begin
      nb = mw[0] ^ mw[mn - mt];
      mw = mw >> 1;
      mw[mn - 1] = nb;
    end
    mri = (mri == int'(mlen)) ? 0 : mri + 1;
    if (mbi == 15) begin
      mbi = 0;
      if (mwc == int'(mreps)) begin mwc = 0; mph = ~mph; end
      else mwc = mwc + 1;
    end else mbi = mbi + 1;
    e = (mkind == 4) ? 1'b0 : (o ^ minv);
  endtask

  function automatic string kind_tag();
    string t;
    case (mkind)
      0: t = "R2";
      1: t = "R3";
      2: t = "R5";
      3: t = "R6";
      default: t = "R7";
    endcase
    if (minv && mkind != 4) t = {t, " with R8 invert"};
    return t;
  endfunction

  task automatic write_cfg(input logic b, input logic [2:0] s, input logic inv,
                           input logic [3:0] len, input logic [31:0] pat,
                           input logic [15:0] word, input logic [3:0] reps, input bit en);
    cfg_bank = b; cfg_sel = s; cfg_inv = inv; cfg_rep_len = len;
    cfg_user_pat = pat; cfg_alt_word = word; cfg_alt_reps = reps;
    cfg_wr = 1'b1; bit_en = en;
    @(negedge clk);
    cfg_wr = 1'b0; bit_en = 1'b0;
    model_load(b, s, inv, len, pat, word, reps);
    chk(tx_bit == 1'b0, "R4 write clears output", 32'(tx_bit), 0);
    chk(sel_err == (mkind == 4), "R7 error flag after write", 32'(sel_err), 32'(mkind == 4));
    last_tx = 1'b0;
  endtask

  task automatic run_bits(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      logic e;
      bit en;
      en = gaps ? (($urandom % 3) != 0) : 1'b1;
      bit_en = en;
      @(negedge clk);
      if (en) begin
        model_next(e);
        chk(tx_bit == e, kind_tag(), 32'(tx_bit), 32'(e));
        last_tx = e;
      end else begin
        chk(tx_bit == last_tx, "R9 hold on gap", 32'(tx_bit), 32'(last_tx));
      end
    end
    bit_en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_wr = 1'b0; bit_en = 1'b0; cfg_bank = 1'b0; cfg_sel = '0;
    cfg_inv = 1'b0; cfg_rep_len = '0; cfg_user_pat = '0; cfg_alt_word = '0; cfg_alt_reps = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_bit == 1'b0, "R1 reset output", 32'(tx_bit), 0);
    chk(sel_err == 1'b0, "R1 reset error flag", 32'(sel_err), 0);
    model_load(1'b0, 3'd0, 1'b0, 4'd0, 32'd0, 16'd0, 4'd0);
    last_tx = 1'b0;
    run_bits(260, 1'b0);                       // R1 default is 2^7-1, two full periods

    write_cfg(1'b0, 3'd1, 1'b0, 0, 0, 0, 0, 1'b0); run_bits(300, 1'b0);   // R2 2^11-1
    write_cfg(1'b0, 3'd2, 1'b0, 0, 0, 0, 0, 1'b1); run_bits(300, 1'b0);   // R2 2^15-1, R4 priority
    write_cfg(1'b1, 3'd0, 1'b1, 0, 0, 0, 0, 1'b0); run_bits(600, 1'b0);   // R2 2^9-1, R8
    write_cfg(1'b1, 3'd2, 1'b0, 0, 0, 0, 0, 1'b1); run_bits(500, 1'b0);   // R2 2^23-1
    write_cfg(1'b1, 3'd1, 1'b0, 0, 0, 0, 0, 1'b0); run_bits(3000, 1'b0);  // R2 2^20-1
    write_cfg(1'b0, 3'd3, 1'b0, 0, 0, 0, 0, 1'b1); run_bits(5000, 1'b0);  // R3 QRSS
    write_cfg(1'b0, 3'd4, 1'b0, 4'd0, 32'h1, 0, 0, 1'b0); run_bits(20, 1'b0);          // R5 period 1
    write_cfg(1'b0, 3'd4, 1'b1, 4'd15, 32'hF00D_A5C3, 0, 0, 1'b1); run_bits(70, 1'b0); // R5 period 16
    write_cfg(1'b0, 3'd4, 1'b0, 4'd4, 32'hFFFF_FFE6, 0, 0, 1'b0); run_bits(40, 1'b1);  // R5 upper bits unused
    write_cfg(1'b0, 3'd5, 1'b0, 0, 0, 16'hC0A1, 4'd0, 1'b0); run_bits(100, 1'b0);      // R6 one repeat
    write_cfg(1'b0, 3'd5, 1'b1, 0, 0, 16'h8001, 4'd3, 1'b1); run_bits(300, 1'b1);      // R6 four repeats
    write_cfg(1'b0, 3'd6, 1'b1, 0, 0, 0, 0, 1'b1); run_bits(30, 1'b0);    // R7 illegal, inverted
    write_cfg(1'b0, 3'd7, 1'b0, 0, 0, 0, 0, 1'b0); run_bits(20, 1'b1);    // R7
    write_cfg(1'b1, 3'd3, 1'b1, 0, 0, 0, 0, 1'b0); run_bits(20, 1'b0);    // R7
    write_cfg(1'b1, 3'd6, 1'b0, 0, 0, 0, 0, 1'b1); run_bits(20, 1'b0);    // R7
    write_cfg(1'b0, 3'd0, 1'b0, 0, 0, 0, 0, 1'b0); run_bits(400, 1'b1);   // R9 gaps on 2^7-1

    for (int k = 0; k < 30; k++) begin
      write_cfg(1'($urandom), 3'($urandom), 1'($urandom), 4'($urandom), $urandom,
                16'($urandom), 4'($urandom), 1'($urandom));
      run_bits(300, 1'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule